// File: doc/BRIEF.md
# DRAM Read/Write Burst Arbiter

This block sits between the request decoder and the DRAM command sequencer. It chooses which queued burst goes to the DRAM next. Reads and writes wait in two separate age-ordered queues. Each entry holds a burst-aligned address, a rank, a bank and a row.

The arbiter keeps a bus direction register. It moves between read and write service according to how full the write queue is. Within the current direction it prefers row hits and then bursts to the rank used last. Among entries that score the same, the oldest wins.

Incoming writes that target a burst already queued for writing are merged into that entry. Incoming reads that target such a burst are answered from the write queue and never reach the DRAM. The sequencer says which banks can take a command through a per-bank ready vector. It takes the offered burst by raising `issue_en`.

Top module: `dram_burst_arbiter`

## Requirements
- R1: After reset both queues are empty, `grant_valid` is 0, `bus_write` is 0 (read direction), and no rank preference applies to the first grant.
- R2: `req_full` is 1 exactly when the occupancy of the queue selected by `req_write`, plus `req_nbursts`, exceeds that queue's depth. A request with `req_full` high or with `req_nbursts` equal to 0 is ignored. An accepted request enqueues one burst.
- R3: Addresses are compared and stored burst-aligned: the low log2(BURST_BYTES) bits are cleared (address AND NOT (BURST_BYTES-1)).
- R4: A write whose aligned address equals that of a queued write, which is not being granted in the same cycle, is merged. No entry is added, so the write queue never holds two entries with the same aligned address.
- R5: A read whose aligned address matches a queued write raises `fwd_hit` in the same cycle. `fwd_idx` gives the age position of that write. The read is not added to the read queue.
- R6: Queue entries are numbered by age, with 0 the oldest. `grant_idx` is the position in the queue of the current direction. A granted entry leaves on the clock edge where `issue_en` is high, and younger entries move down one place. Among equal scores the lowest position wins.
- R7: Only entries whose bank has its `bank_ready` bit set are eligible. The bit index is rank*BANKS_PER_RANK+bank. With no eligible entry in the current direction, `grant_valid` is 0.
- R8: An entry whose row is the row left open in its bank by the last burst to that bank is a row hit. Row hits take priority over all other entries.
- R9: A bank's open row counts as a hit for at most MAX_ROW_HITS consecutive bursts. After that it is treated as closed, and the next burst to that bank reopens a row with a count of 1.
- R10: Among non-hits, and among hits, an entry to the same rank as the previous granted burst is preferred. This preference does not apply to the first grant after reset or after a direction change.
- R11: In read direction the bus turns to writes after any edge that leaves more than WR_HI writes queued. It also turns to writes when the edge leaves the read queue empty and writes pending. The new direction is visible in the next cycle.
- R12: In write direction the bus turns back to reads when the write queue becomes empty. It also turns back when reads are pending, at most WR_LO writes remain, and at least MIN_WR writes have been granted since the turn to writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New request present |
| req_write | input | 1 | Request is a write (1) or a read (0) |
| req_addr | input | ADDR_W | Byte address of the burst |
| req_rank | input | RK_W | Decoded rank |
| req_bank | input | BK_W | Decoded bank within the rank |
| req_row | input | ROW_W | Decoded row |
| req_nbursts | input | NB_W | Bursts the requester needs room for |
| req_full | output | 1 | Target queue cannot take req_nbursts bursts |
| fwd_hit | output | 1 | Read served from a queued write |
| fwd_idx | output | WI_W | Write queue position that served the read |
| bank_ready | input | RANKS*BANKS_PER_RANK | Per-bank ready for a column command |
| issue_en | input | 1 | Sequencer takes the offered burst |
| bus_write | output | 1 | Current direction, 1 = writes |
| grant_valid | output | 1 | A burst is offered |
| grant_idx | output | IDX_W | Queue position of the offered burst |

## Verification
`grant_valid`, `grant_idx`, `req_full`, `fwd_hit` and `fwd_idx` are combinational and are due in the same cycle as the inputs that cause them. Queue contents, open-row counts and the bus direction change on the rising edge that accepts a request or a grant. Their effect is first seen in the cycle after that edge. The bench changes inputs 2 ns after a rising edge and reads combinational results 1 ns later, before the next edge. It reads every registered consequence 2 ns after the edge that produced it, so each expected value is tied to one known edge.

// File: rtl/dram_burst_arbiter.sv
module dram_burst_arbiter #(
  parameter int RQ_DEPTH       = 8,
  parameter int WQ_DEPTH       = 8,
  parameter int RANKS          = 2,
  parameter int BANKS_PER_RANK = 4,
  parameter int ROW_W          = 10,
  parameter int ADDR_W         = 20,
  parameter int BURST_BYTES    = 32,
  parameter int WR_HI          = 6,
  parameter int WR_LO          = 3,
  parameter int MIN_WR         = 4,
  parameter int MAX_ROW_HITS   = 4,
  parameter int NB_W           = 4,
  localparam int NBANK = RANKS * BANKS_PER_RANK,
  localparam int RK_W  = (RANKS > 1) ? $clog2(RANKS) : 1,
  localparam int BK_W  = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
  localparam int NB_IW = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int RI_W  = $clog2(RQ_DEPTH),
  localparam int WI_W  = $clog2(WQ_DEPTH),
  localparam int IDX_W = (RI_W > WI_W) ? RI_W : WI_W,
  localparam int RC_W  = $clog2(RQ_DEPTH + 1),
  localparam int WC_W  = $clog2(WQ_DEPTH + 1),
  localparam int HC_W  = $clog2(MAX_ROW_HITS + 1),
  localparam int MW_W  = $clog2(MIN_WR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [RK_W-1:0]   req_rank,
  input  logic [BK_W-1:0]   req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [NB_W-1:0]   req_nbursts,
  output logic              req_full,
  output logic              fwd_hit,
  output logic [WI_W-1:0]   fwd_idx,
  input  logic [NBANK-1:0]  bank_ready,
  input  logic              issue_en,
  output logic              bus_write,
  output logic              grant_valid,
  output logic [IDX_W-1:0]  grant_idx
);

  logic [ADDR_W-1:0] rq_addr [RQ_DEPTH];
  logic [RK_W-1:0]   rq_rank [RQ_DEPTH];
  logic [BK_W-1:0]   rq_bank [RQ_DEPTH];
  logic [ROW_W-1:0]  rq_row  [RQ_DEPTH];
  logic [ADDR_W-1:0] wq_addr [WQ_DEPTH];
  logic [RK_W-1:0]   wq_rank [WQ_DEPTH];
  logic [BK_W-1:0]   wq_bank [WQ_DEPTH];
  logic [ROW_W-1:0]  wq_row  [WQ_DEPTH];
  logic [RC_W-1:0]   rcnt, rcnt_n;
  logic [WC_W-1:0]   wcnt, wcnt_n;

  logic [ROW_W-1:0]  open_row [NBANK];
  logic [NBANK-1:0]  row_open;
  logic [HC_W-1:0]   hit_cnt  [NBANK];

  logic              bus_wr, dir_n, fresh;
  logic [RK_W-1:0]   last_rank;
  logic [MW_W-1:0]   nwr, nwr_t;

  function automatic logic [NB_IW-1:0] flat(input logic [RK_W-1:0] r, input logic [BK_W-1:0] b);
    return NB_IW'(int'(r) * BANKS_PER_RANK + int'(b));
  endfunction

  logic             rd_found, wr_found;
  logic [RI_W-1:0]  rd_sel;
  logic [WI_W-1:0]  wr_sel;
  logic [1:0]       rd_best, wr_best;

  always_comb begin
    logic [NB_IW-1:0] b;
    logic [1:0]       sc;
    rd_found = 1'b0;
    rd_sel   = '0;
    rd_best  = '0;
    for (int i = 0; i < RQ_DEPTH; i++) begin
      b  = flat(rq_rank[i], rq_bank[i]);
      sc = {row_open[b] && open_row[b] == rq_row[i] && int'(hit_cnt[b]) < MAX_ROW_HITS,
            !fresh && rq_rank[i] == last_rank};
      if (i < int'(rcnt) && bank_ready[b] && (!rd_found || sc > rd_best)) begin
        rd_found = 1'b1;
        rd_sel   = RI_W'(i);
        rd_best  = sc;
      end
    end
  end

  always_comb begin
    logic [NB_IW-1:0] b;
    logic [1:0]       sc;
    wr_found = 1'b0;
    wr_sel   = '0;
    wr_best  = '0;
    for (int i = 0; i < WQ_DEPTH; i++) begin
      b  = flat(wq_rank[i], wq_bank[i]);
      sc = {row_open[b] && open_row[b] == wq_row[i] && int'(hit_cnt[b]) < MAX_ROW_HITS,
            !fresh && wq_rank[i] == last_rank};
      if (i < int'(wcnt) && bank_ready[b] && (!wr_found || sc > wr_best)) begin
        wr_found = 1'b1;
        wr_sel   = WI_W'(i);
        wr_best  = sc;
      end
    end
  end

  assign grant_valid = bus_wr ? wr_found : rd_found;
  assign grant_idx   = bus_wr ? IDX_W'(wr_sel) : IDX_W'(rd_sel);
  assign bus_write   = bus_wr;

  wire take_rd = issue_en && !bus_wr && rd_found;
  wire take_wr = issue_en &&  bus_wr && wr_found;
  wire take    = take_rd || take_wr;

  wire [RK_W-1:0]  g_rank = bus_wr ? wq_rank[wr_sel] : rq_rank[rd_sel];
  wire [BK_W-1:0]  g_bank = bus_wr ? wq_bank[wr_sel] : rq_bank[rd_sel];
  wire [ROW_W-1:0] g_row  = bus_wr ? wq_row[wr_sel]  : rq_row[rd_sel];
  wire [NB_IW-1:0] g_b    = flat(g_rank, g_bank);
  wire             g_hit  = row_open[g_b] && open_row[g_b] == g_row && int'(hit_cnt[g_b]) < MAX_ROW_HITS;

  wire [ADDR_W-1:0] req_base = req_addr & ~ADDR_W'(BURST_BYTES - 1);

  logic            wm_any;
  logic [WI_W-1:0] wm_idx;
  always_comb begin
    wm_any = 1'b0;
    wm_idx = '0;
    for (int i = 0; i < WQ_DEPTH; i++)
      if (i < int'(wcnt) && wq_addr[i] == req_base) begin
        wm_any = 1'b1;
        wm_idx = WI_W'(i);
      end
  end

  assign req_full = req_write ? (int'(wcnt) + int'(req_nbursts) > WQ_DEPTH)
                              : (int'(rcnt) + int'(req_nbursts) > RQ_DEPTH);
  wire accept  = req_valid && !req_full && req_nbursts != '0;
  assign fwd_hit = accept && !req_write && wm_any;
  assign fwd_idx = wm_idx;
  wire rd_push = accept && !req_write && !wm_any;
  wire wr_push = accept && req_write && !(wm_any && !(take_wr && wr_sel == wm_idx));

  assign rcnt_n = RC_W'(int'(rcnt) - int'(take_rd) + int'(rd_push));
  assign wcnt_n = WC_W'(int'(wcnt) - int'(take_wr) + int'(wr_push));
  assign nwr_t  = (take_wr && int'(nwr) < MIN_WR) ? nwr + 1'b1 : nwr;

  always_comb begin
    if (!bus_wr)
      dir_n = int'(wcnt_n) > WR_HI || (rcnt_n == '0 && wcnt_n != '0);
    else
      dir_n = !(wcnt_n == '0 ||
                (rcnt_n != '0 && int'(wcnt_n) <= WR_LO && int'(nwr_t) >= MIN_WR));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < RQ_DEPTH; i++) begin
      if (rd_push && i == int'(rcnt_n) - 1) begin
        rq_addr[i] <= req_base;
        rq_rank[i] <= req_rank;
        rq_bank[i] <= req_bank;
        rq_row[i]  <= req_row;
      end else if (take_rd && i >= int'(rd_sel) && i < RQ_DEPTH - 1) begin
        rq_addr[i] <= rq_addr[(i < RQ_DEPTH - 1) ? i + 1 : i];
        rq_rank[i] <= rq_rank[(i < RQ_DEPTH - 1) ? i + 1 : i];
        rq_bank[i] <= rq_bank[(i < RQ_DEPTH - 1) ? i + 1 : i];
        rq_row[i]  <= rq_row[(i < RQ_DEPTH - 1) ? i + 1 : i];
      end
    end
    for (int i = 0; i < WQ_DEPTH; i++) begin
      if (wr_push && i == int'(wcnt_n) - 1) begin
        wq_addr[i] <= req_base;
        wq_rank[i] <= req_rank;
        wq_bank[i] <= req_bank;
        wq_row[i]  <= req_row;
      end else if (take_wr && i >= int'(wr_sel) && i < WQ_DEPTH - 1) begin
        wq_addr[i] <= wq_addr[(i < WQ_DEPTH - 1) ? i + 1 : i];
        wq_rank[i] <= wq_rank[(i < WQ_DEPTH - 1) ? i + 1 : i];
        wq_bank[i] <= wq_bank[(i < WQ_DEPTH - 1) ? i + 1 : i];
        wq_row[i]  <= wq_row[(i < WQ_DEPTH - 1) ? i + 1 : i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_open <= '0;
      for (int i = 0; i < NBANK; i++) begin
        open_row[i] <= '0;
        hit_cnt[i]  <= '0;
      end
    end else if (take) begin
      if (g_hit) begin
        hit_cnt[g_b] <= hit_cnt[g_b] + 1'b1;
      end else begin
        open_row[g_b] <= g_row;
        row_open[g_b] <= 1'b1;
        hit_cnt[g_b]  <= HC_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt      <= '0;
      wcnt      <= '0;
      bus_wr    <= 1'b0;
      fresh     <= 1'b1;
      last_rank <= '0;
      nwr       <= '0;
    end else begin
      rcnt   <= rcnt_n;
      wcnt   <= wcnt_n;
      bus_wr <= dir_n;
      if (take) last_rank <= g_rank;
      if (dir_n != bus_wr) begin
        nwr   <= '0;
        fresh <= 1'b1;
      end else begin
        nwr <= nwr_t;
        if (take) fresh <= 1'b0;
      end
    end
  end

  assert_hi_forces_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wcnt) > WR_HI) |-> bus_wr);

  assert_min_writes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_wr) && wcnt != '0) |-> (int'($past(nwr_t)) >= MIN_WR));

  assert_grant_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> bank_ready[g_b]);

  assert_fwd_not_queued_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |=> (int'(rcnt) == int'($past(rcnt)) - int'($past(take_rd))));

  always_ff @(posedge clk) begin
    if (rst_n) begin
      assert_no_overflow_R2: assert (int'(rcnt) <= RQ_DEPTH && int'(wcnt) <= WQ_DEPTH);
      for (int i = 0; i < WQ_DEPTH; i++)
        for (int j = 0; j < WQ_DEPTH; j++)
          if (i < j && j < int'(wcnt))
            assert_wq_unique_R4: assert (wq_addr[i] != wq_addr[j]);
      for (int i = 0; i < NBANK; i++)
        assert_row_cap_R9: assert (int'(hit_cnt[i]) <= MAX_ROW_HITS);
    end
  end

endmodule

// File: tb/dram_burst_arbiter_tb.sv
module dram_burst_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [0:0] req_rank = '0, req_bank = '0;
  logic [2:0] req_row = '0, req_nbursts = 3'd1;
  logic       req_full, fwd_hit;
  logic [2:0] fwd_idx;
  logic [3:0] bank_ready = 4'hF;
  logic       issue_en = 1'b0;
  logic       bus_write, grant_valid;
  logic [2:0] grant_idx;

  int nvec = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_burst_arbiter #(
    .RQ_DEPTH(4), .WQ_DEPTH(6), .RANKS(2), .BANKS_PER_RANK(2), .ROW_W(3),
    .ADDR_W(8), .BURST_BYTES(4), .WR_HI(2), .WR_LO(2), .MIN_WR(3),
    .MAX_ROW_HITS(2), .NB_W(3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_rank(req_rank), .req_bank(req_bank), .req_row(req_row),
    .req_nbursts(req_nbursts), .req_full(req_full), .fwd_hit(fwd_hit), .fwd_idx(fwd_idx),
    .bank_ready(bank_ready), .issue_en(issue_en), .bus_write(bus_write),
    .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setreq(input bit w, input int addr, input int rk, input int bk, input int row);
    req_write = w;
    req_addr  = 8'(addr);
    req_rank  = 1'(rk);
    req_bank  = 1'(bk);
    req_row   = 3'(row);
    req_nbursts = 3'd1;
  endtask

  task automatic enq(input bit w, input int addr, input int rk, input int bk, input int row);
    setreq(w, addr, rk, bk, row);
    req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic query(input bit w, input int nb, input int exp, input string tag);
    req_write = w;
    req_nbursts = 3'(nb);
    #1;
    chk(tag, int'(req_full), exp);
    req_nbursts = 3'd1;
    @(posedge clk); #2;
  endtask

  task automatic take(input int exp_idx, input int exp_dir, input string tag);
    chk({tag, " grant_valid"}, int'(grant_valid), 1);
    chk({tag, " grant_idx"}, int'(grant_idx), exp_idx);
    chk({tag, " bus_write"}, int'(bus_write), exp_dir);
    issue_en = 1'b1;
    @(posedge clk); #2;
    issue_en = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;

    // R1: reset state
    chk("R1 grant_valid", int'(grant_valid), 0);
    chk("R1 bus_write", int'(bus_write), 0);
    chk("R1 fwd_hit", int'(fwd_hit), 0);

    // R2: full flag sweep on empty queues
    for (int nb = 0; nb < 8; nb++) begin
      query(1'b0, nb, (nb > 4) ? 1 : 0, "R2 read full");
      query(1'b1, nb, (nb > 6) ? 1 : 0, "R2 write full");
    end

    // R6/R8: oldest first, then row hit priority
    enq(0, 8'h00, 0, 0, 1);
    enq(0, 8'h10, 0, 1, 2);
    enq(0, 8'h20, 0, 0, 1);
    take(0, 0, "R6 oldest first");
    take(1, 0, "R8 row hit wins");
    take(0, 0, "R6 remaining");
    chk("R7 empty no grant", int'(grant_valid), 0);

    // R9: bank 0 row 1 used twice, no longer a hit
    enq(0, 8'h40, 0, 1, 3);
    enq(0, 8'h50, 0, 0, 1);
    take(0, 0, "R9 row cap tie to oldest");
    take(0, 0, "R9 reopen");

    // R10: same-rank preference
    enq(0, 8'h60, 1, 0, 5);
    enq(0, 8'h70, 0, 1, 4);
    take(1, 0, "R10 same rank preferred");
    take(0, 0, "R10 other rank");

    // R7: bank not ready blocks the grant
    bank_ready = 4'b1011;
    enq(0, 8'h64, 1, 0, 5);
    chk("R7 bank not ready", int'(grant_valid), 0);
    bank_ready = 4'hF;
    #1;
    take(0, 0, "R7 bank ready");

    // R11: write watermark
    enq(0, 8'h01, 0, 1, 4);
    enq(1, 8'h80, 0, 0, 1);
    enq(1, 8'h84, 0, 0, 1);
    chk("R11 at watermark stays read", int'(bus_write), 0);
    enq(1, 8'h88, 1, 1, 2);
    chk("R11 above watermark turns write", int'(bus_write), 1);
    enq(1, 8'h8C, 1, 1, 2);

    // R3/R4: unaligned write merges into 0x80
    enq(1, 8'h81, 0, 0, 1);
    query(1'b1, 2, 0, "R4 merged write adds no entry");

    // R3/R5: read 0x8A forwarded from write at position 2
    setreq(0, 8'h8A, 1, 1, 2);
    req_valid = 1'b1;
    #1;
    chk("R5 fwd_hit", int'(fwd_hit), 1);
    chk("R5 fwd_idx", int'(fwd_idx), 2);
    @(posedge clk); #2;
    req_valid = 1'b0;
    query(1'b0, 3, 0, "R5 forwarded read not queued");

    // R12: minimum writes before turning back
    take(0, 1, "R12 write 1");
    chk("R12 stays write after 1", int'(bus_write), 1);
    take(0, 1, "R12 write 2");
    chk("R12 min writes holds write", int'(bus_write), 1);
    take(0, 1, "R12 write 3");
    chk("R12 turns read", int'(bus_write), 0);
    take(0, 0, "R12 pending read");
    chk("R11 idle drains writes", int'(bus_write), 1);
    take(0, 1, "R11 last write");
    chk("R12 empty queue turns read", int'(bus_write), 0);
    chk("R12 nothing left", int'(grant_valid), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule